// File: doc/BRIEF.md
# Credit-Issuing Channel Receiver with Per-Plane Buffers

This block is the receiving end of a credit-based channel. The traffic on the channel is split into several independent flow-control planes, and an optional pool of shared credits can be spent on any plane. The receiver owns the buffering. Each plane has a small queue. Every queue is deep enough for that plane's own dedicated credits plus the whole shared pool. A transmitter may send only with a credit it already holds. Every incoming transfer carries a plane index and a flag saying which kind of credit it spent.

After reset the block hands out its initial credits one pulse at a time. It stores each accepted payload in the queue of the plane it is tagged with. It presents every queue downstream as a valid/ready stream. When an entry leaves a queue, the block returns a credit of the same kind that entry consumed. Returns that cannot go out yet wait in per-plane counters and in one shared counter. They are issued at a rate of at most one pulse per plane and one shared pulse per cycle.

The block also keeps two sticky error flags. One records transfers sent without a credit. The other records transfers that arrived without the one-cycle look-ahead hint. The look-ahead hint is registered and offered as a wake signal for the storage.

A three-state machine sequences credit issue:
- `GS_HOLD` is the cycle right after reset. No credit is issued in it.
- `GS_HOLD` always moves to `GS_FILL` on the next edge.
- `GS_FILL` issues the initial credits.
- `GS_FILL` moves to `GS_RUN` once every return counter is empty.
- `GS_RUN` keeps issuing returns as entries drain. It stays in `GS_RUN` until reset.

Credits are issued in both `GS_FILL` and `GS_RUN`.

Top module: `crx_receiver`

## Requirements
- R1: While reset is active, and in the first cycle after release (state `GS_HOLD`), `crd_ded` and `crd_sh` are low.
- R2: Outstanding credits never exceed `DED` per plane or `SH` shared (each 1..15). With no traffic, no pulse follows the initial grant.
- R3: A transfer is accepted when `in_valid` is high and a credit of the kind shown by `in_shared` (1 = shared, 0 = dedicated) is held for plane `in_plane`. Its payload is then visible on `out_valid[p]`/`out_data[p*DW +: DW]` in the following cycle. Each plane's entries come out in arrival order.
- R4: Draining an entry returns a credit of the kind it consumed: `crd_ded[p]` for dedicated, `crd_sh` for shared. With no backlog, the return pulse is high in the second cycle after the draining edge, and not in the first.
- R5: A plane whose `out_ready` is held low does not stop another plane that holds credit from accepting and draining.
- R6: A transfer with no held credit of its kind, or with `in_plane` ≥ `NUM_PL`, is discarded and sets `err_credit`. The flag stays set until reset.
- R7: `in_valid` high in a cycle whose preceding cycle had `in_pending` low sets `err_pending`. The flag stays set until reset.
- R8: `wake` equals `in_pending` delayed by one cycle.
- R9: After release, the FSM goes `GS_HOLD` → `GS_FILL` → `GS_RUN`. Exactly `DED` pulses per plane and `SH` shared pulses are issued, at most one per output per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_pending | input | 1 | Look-ahead: a transfer may come next cycle |
| in_valid | input | 1 | A transfer is present |
| in_plane | input | PLW | Plane index of the transfer |
| in_shared | input | 1 | 1 = transfer spent a shared credit |
| in_data | input | DW | Payload |
| crd_ded | output | NUM_PL | One dedicated credit pulse per plane |
| crd_sh | output | 1 | One shared credit pulse |
| out_valid | output | NUM_PL | Plane queue not empty |
| out_data | output | NUM_PL*DW | Head payload of each plane |
| out_ready | input | NUM_PL | Downstream accepts the plane head |
| wake | output | 1 | Registered look-ahead, storage enable hint |
| err_credit | output | 1 | Sticky: transfer without matching credit |
| err_pending | output | 1 | Sticky: transfer without prior look-ahead |

## Verification
The assertions assume that the transmitter never spends more credits than the receiver issued. With that assumption, the conservation and queue-overflow properties hold. They also assume that `rst_n` is released on a clock edge.

The stimulus keeps within these limits in two ways. The bench counts the credit pulses it sees and spends a credit only in a later cycle. It also holds `in_pending` high during normal traffic.

Only two cases break these rules on purpose, and both are there to raise the error flags. One is a shared transfer sent with no shared credit held. The other is a transfer sent after `in_pending` was low. The first case is discarded by the block, so the accounting invariants still hold.

// File: rtl/crx_pkg.sv
package crx_pkg;

    typedef enum logic [1:0] {
        GS_HOLD = 2'd0,
        GS_FILL = 2'd1,
        GS_RUN  = 2'd2
    } grant_st_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/crx_plane_fifo.sv
module crx_plane_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int OW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_sh,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          pop_ded,
    output logic          pop_sh,
    output logic [OW-1:0] occ_ded
);
    localparam int PW = crx_pkg::idx_w(DEPTH);

    logic [DW:0]   mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [OW-1:0] cnt_q, nded_q;
    logic          pop, head_sh;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] v);
        return (v == PW'(DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    assign rd_valid = (cnt_q != '0);
    assign rd_data  = mem[rp_q][DW-1:0];
    assign head_sh  = mem[rp_q][DW];
    assign pop      = rd_valid && rd_ready;
    assign pop_ded  = pop && !head_sh;
    assign pop_sh   = pop && head_sh;
    assign occ_ded  = nded_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp_q] <= {wr_sh, wr_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            nded_q <= '0;
        end else begin
            if (wr_en) wp_q <= bump(wp_q);
            if (pop)   rp_q <= bump(rp_q);
            cnt_q  <= cnt_q + OW'(wr_en) - OW'(pop);
            nded_q <= nded_q + OW'(wr_en && !wr_sh) - OW'(pop_ded);
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(cnt_q) < DEPTH));

endmodule

// File: rtl/crx_credit_ctrl.sv
module crx_credit_ctrl #(
    parameter int NUM_PL = 3,
    parameter int DED    = 2,
    parameter int SH     = 2,
    parameter int OW     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_pending,
    input  logic                          in_valid,
    input  logic [crx_pkg::idx_w(NUM_PL)-1:0] in_plane,
    input  logic                          in_shared,
    input  logic [NUM_PL-1:0]             pop_ded,
    input  logic [NUM_PL-1:0]             pop_sh,
    input  logic [NUM_PL*OW-1:0]          occ_ded,
    output logic [NUM_PL-1:0]             wr_en,
    output logic [NUM_PL-1:0]             crd_ded,
    output logic                          crd_sh,
    output logic                          wake,
    output logic                          err_credit,
    output logic                          err_pending
);
    import crx_pkg::*;

    localparam int CW  = 5;
    localparam int PLW = idx_w(NUM_PL);

    grant_st_e         st_q, st_d;
    logic              grant_en;
    logic [NUM_PL-1:0] ret_nz, ded_avail;
    logic [CW-1:0]     sh_ret_q, sh_held_q;
    logic              sh_iss, crd_sh_q;
    logic              plane_ok, has_cr, accept, acc_sh;
    logic [PLW-1:0]    plane_ix;
    logic              pend_q, err_cr_q, err_pd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GS_HOLD;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GS_HOLD: st_d = GS_FILL;
            GS_FILL: st_d = ((ret_nz == '0) && (sh_ret_q == '0)) ? GS_RUN : GS_FILL;
            GS_RUN:  st_d = GS_RUN;
            default: st_d = GS_HOLD;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        unique case (st_q)
            GS_HOLD: grant_en = 1'b0;
            GS_FILL: grant_en = 1'b1;
            GS_RUN:  grant_en = 1'b1;
            default: grant_en = 1'b0;
        endcase
    end

    // acceptance decode
    assign plane_ok = (int'(in_plane) < NUM_PL);
    assign plane_ix = plane_ok ? in_plane : '0;
    assign has_cr   = in_shared ? (sh_held_q != '0) : ded_avail[plane_ix];
    assign accept   = in_valid && plane_ok && has_cr;
    assign acc_sh   = accept && in_shared;

    for (genvar p = 0; p < NUM_PL; p++) begin : g_pl
        logic [CW-1:0] ret_q, held_q;
        logic          iss, crd_q, acc_d;

        assign wr_en[p]     = accept && (plane_ix == PLW'(p));
        assign acc_d        = wr_en[p] && !in_shared;
        assign iss          = grant_en && (ret_q != '0);
        assign ret_nz[p]    = (ret_q != '0);
        assign ded_avail[p] = (held_q != '0);
        assign crd_ded[p]   = crd_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ret_q  <= CW'(DED);
                held_q <= '0;
                crd_q  <= 1'b0;
            end else begin
                ret_q  <= ret_q - CW'(iss) + CW'(pop_ded[p]);
                held_q <= held_q + CW'(crd_q) - CW'(acc_d);
                crd_q  <= iss;
            end
        end

        assert_ded_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
            int'(held_q) <= DED);

        assert_ded_conserve_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(held_q) + int'(crd_q) + int'(ret_q) + int'(occ_ded[p*OW +: OW])) == DED);
    end

    assign sh_iss = grant_en && (sh_ret_q != '0);
    assign crd_sh = crd_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_ret_q  <= CW'(SH);
            sh_held_q <= '0;
            crd_sh_q  <= 1'b0;
        end else begin
            sh_ret_q  <= sh_ret_q - CW'(sh_iss) + CW'($countones(pop_sh));
            sh_held_q <= sh_held_q + CW'(crd_sh_q) - CW'(acc_sh);
            crd_sh_q  <= sh_iss;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            err_cr_q <= 1'b0;
            err_pd_q <= 1'b0;
        end else begin
            pend_q   <= in_pending;
            err_cr_q <= err_cr_q | (in_valid && !accept);
            err_pd_q <= err_pd_q | (in_valid && !pend_q);
        end
    end

    assign wake        = pend_q;
    assign err_credit  = err_cr_q;
    assign err_pending = err_pd_q;

    assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GS_HOLD) |-> ((crd_ded == '0) && !crd_sh));

    assert_sh_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sh_held_q) <= SH);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_credit) |-> err_credit);

    assert_pend_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wake) |=> err_pending);

    assert_fsm_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GS_RUN) |=> (st_q == GS_RUN));

endmodule

// File: rtl/crx_receiver.sv
module crx_receiver #(
    parameter int NUM_PL = 3,
    parameter int DED    = 2,
    parameter int SH     = 2,
    parameter int DW     = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_pending,
    input  logic                              in_valid,
    input  logic [crx_pkg::idx_w(NUM_PL)-1:0] in_plane,
    input  logic                              in_shared,
    input  logic [DW-1:0]                     in_data,
    output logic [NUM_PL-1:0]                 crd_ded,
    output logic                              crd_sh,
    output logic [NUM_PL-1:0]                 out_valid,
    output logic [NUM_PL*DW-1:0]              out_data,
    input  logic [NUM_PL-1:0]                 out_ready,
    output logic                              wake,
    output logic                              err_credit,
    output logic                              err_pending
);
    localparam int DEPTH = DED + SH;
    localparam int OW    = $clog2(DEPTH + 1);

    logic [NUM_PL-1:0]    wr_en, pop_ded, pop_sh;
    logic [NUM_PL*OW-1:0] occ_ded;

    crx_credit_ctrl #(
        .NUM_PL(NUM_PL), .DED(DED), .SH(SH), .OW(OW)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_pending(in_pending), .in_valid(in_valid),
        .in_plane(in_plane), .in_shared(in_shared),
        .pop_ded(pop_ded), .pop_sh(pop_sh), .occ_ded(occ_ded),
        .wr_en(wr_en), .crd_ded(crd_ded), .crd_sh(crd_sh),
        .wake(wake), .err_credit(err_credit), .err_pending(err_pending)
    );

    for (genvar p = 0; p < NUM_PL; p++) begin : g_q
        crx_plane_fifo #(.DW(DW), .DEPTH(DEPTH), .OW(OW)) i_fifo (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en[p]), .wr_data(in_data), .wr_sh(in_shared),
            .rd_ready(out_ready[p]), .rd_valid(out_valid[p]),
            .rd_data(out_data[p*DW +: DW]),
            .pop_ded(pop_ded[p]), .pop_sh(pop_sh[p]),
            .occ_ded(occ_ded[p*OW +: OW])
        );
    end

endmodule

// File: tb/test_crx_receiver.sv
`timescale 1ns/100ps
module test_crx_receiver;
    localparam int NPL = 3, DED = 2, SH = 2, DW = 8, PLW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                in_pending = 1'b0, in_valid = 1'b0, in_shared = 1'b0;
    logic [PLW-1:0]      in_plane = '0;
    logic [DW-1:0]       in_data = '0;
    logic [NPL-1:0]      crd_ded, out_valid;
    logic [NPL-1:0]      out_ready = '0;
    logic                crd_sh, wake, err_credit, err_pending;
    logic [NPL*DW-1:0]   out_data;

    crx_receiver #(.NUM_PL(NPL), .DED(DED), .SH(SH), .DW(DW)) i_crx_receiver (
        .clk(clk), .rst_n(rst_n), .in_pending(in_pending), .in_valid(in_valid),
        .in_plane(in_plane), .in_shared(in_shared), .in_data(in_data),
        .crd_ded(crd_ded), .crd_sh(crd_sh), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .wake(wake),
        .err_credit(err_credit), .err_pending(err_pending)
    );

    int n_chk = 0, n_bad = 0;
    int ded_cr [NPL] = '{default: 0};
    int sh_cr = 0;
    logic [PLW+DW-1:0] exp_q [$];
    logic [NPL-1:0] rdy_mask = '0, rdy_force = '0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // credit monitor: the bench acts as the transmitter holding credits
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            for (int p = 0; p < NPL; p++) if (crd_ded[p]) ded_cr[p]++;
            if (crd_sh) sh_cr++;
        end
    end

    // downstream ready generator
    always @(negedge clk) begin
        #0.5;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (lfsr[NPL-1:0] & rdy_mask) | rdy_force;
    end

    // scoreboard monitor (R3 ordering per plane)
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            for (int p = 0; p < NPL; p++) begin
                if (out_valid[p] && out_ready[p]) begin
                    int idx;
                    idx = -1;
                    for (int i = 0; i < exp_q.size(); i++) begin
                        if (exp_q[i][PLW+DW-1:DW] == PLW'(p)) begin
                            idx = i;
                            break;
                        end
                    end
                    if (idx < 0) begin
                        check(1'b0, "R3 unexpected item", int'(out_data[p*DW +: DW]), -1);
                    end else begin
                        check(out_data[p*DW +: DW] == exp_q[idx][DW-1:0], "R3 order/data",
                              int'(out_data[p*DW +: DW]), int'(exp_q[idx][DW-1:0]));
                        exp_q.delete(idx);
                    end
                end
            end
        end
    end

    task automatic send(input int p, input bit want_sh, input logic [DW-1:0] d);
        bit use_sh;
        while (ded_cr[p] == 0 && sh_cr == 0) @(negedge clk);
        @(negedge clk);
        use_sh = (want_sh && sh_cr > 0) || (ded_cr[p] == 0);
        if (use_sh) sh_cr--; else ded_cr[p]--;
        in_valid = 1'b1; in_plane = PLW'(p); in_shared = use_sh; in_data = d;
        exp_q.push_back({PLW'(p), d});
        @(negedge clk);
        in_valid = 1'b0; in_shared = 1'b0;
    endtask

    function automatic int count_plane(input int p);
        int n = 0;
        for (int i = 0; i < exp_q.size(); i++)
            if (exp_q[i][PLW+DW-1:DW] == PLW'(p)) n++;
        return n;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        check(crd_ded == '0 && !crd_sh, "R1 credits low in reset", int'({crd_ded, crd_sh}), 0);
        check(out_valid == '0 && !err_credit && !err_pending, "R1 reset outputs",
              int'({out_valid, err_credit, err_pending}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(crd_ded == '0 && !crd_sh, "R1 quiet first cycle", int'({crd_ded, crd_sh}), 0);
        repeat (10) @(negedge clk);
        for (int p = 0; p < NPL; p++)
            check(ded_cr[p] == DED, "R9 initial dedicated grant", ded_cr[p], DED);
        check(sh_cr == SH, "R9 initial shared grant", sh_cr, SH);
        in_pending = 1'b1;
        repeat (5) @(negedge clk);
        for (int p = 0; p < NPL; p++)
            check(ded_cr[p] == DED, "R2 no extra dedicated", ded_cr[p], DED);
        check(sh_cr == SH, "R2 no extra shared", sh_cr, SH);

        // dedicated latency and return timing
        send(0, 1'b0, 8'hA5);
        check(out_valid[0] == 1'b1, "R3 visible next cycle", int'(out_valid[0]), 1);
        check(out_data[7:0] == 8'hA5, "R3 payload", int'(out_data[7:0]), 8'hA5);
        rdy_force = 3'b001;
        @(negedge clk);
        rdy_force = '0;
        check(crd_ded[0] == 1'b0, "R4 no return in first cycle", int'(crd_ded[0]), 0);
        @(negedge clk);
        check(crd_ded[0] == 1'b1, "R4 dedicated return", int'(crd_ded[0]), 1);
        check(crd_sh == 1'b0, "R4 kind dedicated", int'(crd_sh), 0);

        // shared entry on plane 1 returns a shared credit
        send(1, 1'b1, 8'h3C);
        check(out_valid[1] == 1'b1, "R3 shared stored in plane", int'(out_valid[1]), 1);
        rdy_force = 3'b010;
        @(negedge clk);
        rdy_force = '0;
        check(crd_sh == 1'b0, "R4 no shared return first cycle", int'(crd_sh), 0);
        @(negedge clk);
        check(crd_sh == 1'b1, "R4 shared return", int'(crd_sh), 1);
        check(crd_ded[1] == 1'b0, "R4 kind shared", int'(crd_ded[1]), 0);
        repeat (4) @(negedge clk);

        // plane independence
        rdy_mask = 3'b110;
        send(0, 1'b0, 8'h11);
        for (int i = 0; i < 8; i++) send(1, i[0], DW'(8'h20 + i));
        repeat (30) @(negedge clk);
        check(count_plane(1) == 0, "R5 plane 1 drained", count_plane(1), 0);
        check(out_valid[0] == 1'b1, "R5 plane 0 still stalled", int'(out_valid[0]), 1);
        rdy_mask = 3'b111;

        // mixed traffic
        for (int i = 0; i < 40; i++)
            send($urandom_range(0, NPL - 1), 1'($urandom_range(0, 1)), DW'(i));
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R3 all items delivered", exp_q.size(), 0);
        for (int p = 0; p < NPL; p++)
            check(ded_cr[p] == DED, "R4 dedicated credits all returned", ded_cr[p], DED);
        check(sh_cr == SH, "R4 shared credits all returned", sh_cr, SH);
        check(err_credit == 1'b0 && err_pending == 1'b0, "R6 no error in legal traffic",
              int'({err_credit, err_pending}), 0);

        // shared credit exhaustion and discard
        rdy_mask = '0;
        repeat (2) @(negedge clk);
        send(2, 1'b1, 8'hC1);
        send(2, 1'b1, 8'hC2);
        check(sh_cr == 0, "R6 shared pool spent", sh_cr, 0);
        in_valid = 1'b1; in_plane = 2'd2; in_shared = 1'b1; in_data = 8'hEE;
        @(negedge clk);
        in_valid = 1'b0; in_shared = 1'b0;
        check(err_credit == 1'b1, "R6 error set", int'(err_credit), 1);
        rdy_mask = 3'b111;
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6 legal items drained", exp_q.size(), 0);
        check(out_valid[2] == 1'b0, "R6 illegal item discarded", int'(out_valid[2]), 0);
        check(err_credit == 1'b1, "R6 error sticky", int'(err_credit), 1);

        // look-ahead hint and its error
        check(err_pending == 1'b0, "R7 clear before test", int'(err_pending), 0);
        in_pending = 1'b0;
        @(negedge clk);
        check(wake == 1'b0, "R8 wake follows low", int'(wake), 0);
        in_pending = 1'b1;
        @(negedge clk);
        check(wake == 1'b1, "R8 wake follows high", int'(wake), 1);
        in_pending = 1'b0;
        @(negedge clk);
        send(0, 1'b0, 8'h77);
        check(err_pending == 1'b1, "R7 missing look-ahead flagged", int'(err_pending), 1);
        in_pending = 1'b1;
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R3 final drain", exp_q.size(), 0);
        check(err_pending == 1'b1, "R7 error sticky", int'(err_pending), 1);

        summary();
        $finish;
    end

endmodule